// File: doc/BRIEF.md
# VGA Raster Timing Generator

This block produces the raster timing for a 640x480 display with 3-bit colour. It runs on a single 50 MHz system clock and makes its own 25 MHz pixel-enable tick, so no second clock domain is needed. The tick is also an output, so a downstream pixel generator can step in lockstep with the counters. A horizontal counter and a line counter are paced only by that tick. Because count 0 is the first visible pixel and the first visible line, the counts are the screen coordinates. The top-left visible pixel is (0,0) and the bottom-right is (639,479).

Horizontal and vertical sync are decoded from the counters and registered, so they leave the block glitch-free and line up with the coordinates they belong to. A display-enable flag marks the visible area. The 3-bit colour input is passed through while that flag is high and forced to black while it is low. Every porch, pulse and active length is a parameter, and the defaults give the standard 800x525 raster.

Top module: `vga_timing_gen`

## Requirements
- R1: While rst_ni is low, pixel_x_o and pixel_y_o are 0, hsync_o and vsync_o are 1, and pix_tick_o is 0.
- R2: After reset is released, pix_tick_o is high in the first clock cycle and then alternates high and low on every clock cycle, giving half the system clock rate.
- R3: pixel_x_o increments by one on each clock edge where pix_tick_o is high and wraps from 799 to 0. It holds its value on cycles with pix_tick_o low, so each line spans 800 ticks.
- R4: pixel_y_o increments by one only on a tick where pixel_x_o wraps from 799 to 0, and wraps from 524 to 0. It holds its value at all other times, so each frame spans 525 lines.
- R5: hsync_o is low exactly while pixel_x_o is in 656..751 inclusive, and high otherwise, in the same cycle.
- R6: vsync_o is low exactly while pixel_y_o is 490 or 491, and high otherwise, in the same cycle.
- R7: disp_en_o is high exactly when pixel_x_o < 640 and pixel_y_o < 480.
- R8: rgb_o equals rgb_i while disp_en_o is high and is 3'b000 while it is low. Bit 2 is red, bit 1 is green and bit 0 is blue, so 3'b001 is blue, 3'b110 is yellow and 3'b111 is white.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock (50 MHz nominal) |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rgb_i | input | 3 | Colour from the pixel generator, {R,G,B} |
| pix_tick_o | output | 1 | Pixel-enable tick, high every second clock cycle |
| hsync_o | output | 1 | Horizontal sync, active low |
| vsync_o | output | 1 | Vertical sync, active low |
| disp_en_o | output | 1 | High inside the visible area |
| pixel_x_o | output | 10 | Current column (horizontal count) |
| pixel_y_o | output | 10 | Current line (vertical count) |
| rgb_o | output | 3 | Colour gated to black outside the visible area |

## Verification
The assertions assume the active region and front porch together are non-zero, so that count 0 never lies inside a sync pulse. They also assume rgb_i can take any value on any cycle, since the gating must hold without knowing the colour source. The bench changes rgb_i to a random value from a fixed seed on every cycle and adds directed colours and a reset in the middle of a frame. Full frames of the default raster take too long to run, so a second instance with shortened porch and pulse parameters covers vertical sync and the frame wrap.

// File: rtl/vga_tim_pkg.sv
package vga_tim_pkg;
  localparam int unsigned H_ACTIVE_D = 640;
  localparam int unsigned H_FRONT_D  = 16;
  localparam int unsigned H_PULSE_D  = 96;
  localparam int unsigned H_BACK_D   = 48;
  localparam int unsigned V_ACTIVE_D = 480;
  localparam int unsigned V_FRONT_D  = 10;
  localparam int unsigned V_PULSE_D  = 2;
  localparam int unsigned V_BACK_D   = 33;
  localparam int unsigned COORD_W_D  = 10;
  localparam int unsigned RGB_W      = 3;

  typedef struct packed {
    logic r;
    logic g;
    logic b;
  } rgb_t;
endpackage

// File: rtl/vga_pix_tick.sv
module vga_pix_tick (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  logic tick_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) tick_q <= 1'b0;
    else         tick_q <= ~tick_q;
  end

  assign tick_o = tick_q;

  AST_TICK_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> !tick_o); // R2
  AST_TICK_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_o |=> tick_o); // R2
endmodule

// File: rtl/vga_axis_cnt.sv
module vga_axis_cnt #(
  parameter int unsigned ACTIVE = 640,
  parameter int unsigned FRONT  = 16,
  parameter int unsigned PULSE  = 96,
  parameter int unsigned BACK   = 48,
  parameter int unsigned W      = 10
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         step_i,
  output logic [W-1:0] cnt_o,
  output logic         wrap_o,
  output logic         vis_o,
  output logic         sync_no
);
  localparam int unsigned TOTAL    = ACTIVE + FRONT + PULSE + BACK;
  localparam logic [W-1:0] LAST    = W'(TOTAL - 1);
  localparam logic [W-1:0] SYNC_LO = W'(ACTIVE + FRONT);
  localparam logic [W-1:0] SYNC_HI = W'(ACTIVE + FRONT + PULSE - 1);
  localparam logic [W-1:0] ACT_W   = W'(ACTIVE);

  logic [W-1:0] cnt_q, cnt_d;
  logic         sync_q;

  assign wrap_o = step_i && (cnt_q == LAST);

  always_comb begin
    cnt_d = cnt_q;
    if (step_i) cnt_d = (cnt_q == LAST) ? '0 : cnt_q + W'(1);
  end

  // sync decoded from the next count so it stays aligned with cnt_o
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      sync_q <= 1'b1;
    end else begin
      cnt_q  <= cnt_d;
      sync_q <= !((cnt_d >= SYNC_LO) && (cnt_d <= SYNC_HI));
    end
  end

  assign cnt_o   = cnt_q;
  assign vis_o   = cnt_q < ACT_W;
  assign sync_no = sync_q;

  AST_CNT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !step_i |=> $stable(cnt_q)); // R3, R4
  AST_CNT_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap_o |=> (cnt_q == '0)); // R3, R4
  AST_CNT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && cnt_q != LAST) |=> (cnt_q == $past(cnt_q) + W'(1))); // R3, R4
  AST_SYNC_WIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_no == !((cnt_q >= SYNC_LO) && (cnt_q <= SYNC_HI))); // R5, R6
endmodule

// File: rtl/vga_timing_gen.sv
module vga_timing_gen
  import vga_tim_pkg::*;
#(
  parameter int unsigned H_ACTIVE = H_ACTIVE_D,
  parameter int unsigned H_FRONT  = H_FRONT_D,
  parameter int unsigned H_PULSE  = H_PULSE_D,
  parameter int unsigned H_BACK   = H_BACK_D,
  parameter int unsigned V_ACTIVE = V_ACTIVE_D,
  parameter int unsigned V_FRONT  = V_FRONT_D,
  parameter int unsigned V_PULSE  = V_PULSE_D,
  parameter int unsigned V_BACK   = V_BACK_D,
  parameter int unsigned COORD_W  = COORD_W_D
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [RGB_W-1:0]   rgb_i,
  output logic               pix_tick_o,
  output logic               hsync_o,
  output logic               vsync_o,
  output logic               disp_en_o,
  output logic [COORD_W-1:0] pixel_x_o,
  output logic [COORD_W-1:0] pixel_y_o,
  output logic [RGB_W-1:0]   rgb_o
);
  logic tick, h_wrap, v_wrap, h_vis, v_vis;
  rgb_t rgb_in, rgb_out;

  vga_pix_tick u_tick (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_o (tick)
  );

  vga_axis_cnt #(
    .ACTIVE (H_ACTIVE), .FRONT (H_FRONT), .PULSE (H_PULSE), .BACK (H_BACK), .W (COORD_W)
  ) u_h_cnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .step_i  (tick),
    .cnt_o   (pixel_x_o),
    .wrap_o  (h_wrap),
    .vis_o   (h_vis),
    .sync_no (hsync_o)
  );

  vga_axis_cnt #(
    .ACTIVE (V_ACTIVE), .FRONT (V_FRONT), .PULSE (V_PULSE), .BACK (V_BACK), .W (COORD_W)
  ) u_v_cnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .step_i  (h_wrap),
    .cnt_o   (pixel_y_o),
    .wrap_o  (v_wrap),
    .vis_o   (v_vis),
    .sync_no (vsync_o)
  );

  assign pix_tick_o = tick;
  assign disp_en_o  = h_vis && v_vis;
  assign rgb_in     = rgb_t'(rgb_i);
  assign rgb_out    = disp_en_o ? rgb_in : '0;
  assign rgb_o      = rgb_out;

  AST_RGB_BLANK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !disp_en_o |-> (rgb_o == '0)); // R8
  AST_Y_ONLY_ON_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !h_wrap |=> $stable(pixel_y_o)); // R4
  AST_FRAME_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    v_wrap |=> (pixel_x_o == '0 && pixel_y_o == '0)); // R4
endmodule

// File: tb/vga_timing_gen_tb_top.sv
module vga_timing_gen_tb_top;
  // small raster: H 8/2/3/2 = 15, V 6/1/2/3 = 12
  localparam int SH_A = 8, SH_F = 2, SH_P = 3, SH_B = 2;
  localparam int SV_A = 6, SV_F = 1, SV_P = 2, SV_B = 3;
  localparam int NCYC = 6000;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic [2:0] rgb_i = 3'b000;
  always #5 clk = ~clk;

  logic       tk_d, hs_d, vs_d, de_d, tk_s, hs_s, vs_s, de_s;
  logic [9:0] x_d, y_d, x_s, y_s;
  logic [2:0] rgb_d, rgb_s;

  vga_timing_gen dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .rgb_i(rgb_i), .pix_tick_o(tk_d),
    .hsync_o(hs_d), .vsync_o(vs_d), .disp_en_o(de_d),
    .pixel_x_o(x_d), .pixel_y_o(y_d), .rgb_o(rgb_d));

  vga_timing_gen #(
    .H_ACTIVE(SH_A), .H_FRONT(SH_F), .H_PULSE(SH_P), .H_BACK(SH_B),
    .V_ACTIVE(SV_A), .V_FRONT(SV_F), .V_PULSE(SV_P), .V_BACK(SV_B)
  ) dut_s (
    .clk_i(clk), .rst_ni(rst_ni), .rgb_i(rgb_i), .pix_tick_o(tk_s),
    .hsync_o(hs_s), .vsync_o(vs_s), .disp_en_o(de_s),
    .pixel_x_o(x_s), .pixel_y_o(y_s), .rgb_o(rgb_s));

  int n_chk = 0, n_fail = 0;
  int mt, mxd, myd, mxs, mys;
  bit done = 0;

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int sync_exp(int c, int a, int f, int p);
    return (c >= a + f && c < a + f + p) ? 0 : 1;
  endfunction

  function automatic int rgb_exp(int x, int y, int ha, int va, int c);
    return (x < ha && y < va) ? c : 0;
  endfunction

  task automatic check_all(input string tag);
    chk({tag, " R2 tick"}, int'(tk_d), mt);
    chk({tag, " R2 tick small"}, int'(tk_s), mt);
    chk({tag, " R3 x"}, int'(x_d), mxd);
    chk({tag, " R4 y"}, int'(y_d), myd);
    chk({tag, " R3 x small"}, int'(x_s), mxs);
    chk({tag, " R4 y small"}, int'(y_s), mys);
    chk({tag, " R5 hsync"}, int'(hs_d), sync_exp(mxd, 640, 16, 96));
    chk({tag, " R6 vsync"}, int'(vs_d), sync_exp(myd, 480, 10, 2));
    chk({tag, " R5 hsync small"}, int'(hs_s), sync_exp(mxs, SH_A, SH_F, SH_P));
    chk({tag, " R6 vsync small"}, int'(vs_s), sync_exp(mys, SV_A, SV_F, SV_P));
    chk({tag, " R7 de"}, int'(de_d), int'(mxd < 640 && myd < 480));
    chk({tag, " R7 de small"}, int'(de_s), int'(mxs < SH_A && mys < SV_A));
    chk({tag, " R8 rgb"}, int'(rgb_d), rgb_exp(mxd, myd, 640, 480, int'(rgb_i)));
    chk({tag, " R8 rgb small"}, int'(rgb_s), rgb_exp(mxs, mys, SH_A, SV_A, int'(rgb_i)));
  endtask

  initial begin
    void'($urandom(32'h5eed_1234));
    mt = 0; mxd = 0; myd = 0; mxs = 0; mys = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check_all("R1 reset");
    rst_ni = 1'b1;
    for (int cyc = 0; cyc < NCYC; cyc++) begin
      @(posedge clk);
      if (!rst_ni) begin
        mt = 0; mxd = 0; myd = 0; mxs = 0; mys = 0;
      end else begin
        if (mt == 1) begin
          if (mxd == 799) begin mxd = 0; myd = (myd == 524) ? 0 : myd + 1; end
          else mxd++;
          if (mxs == SH_A + SH_F + SH_P + SH_B - 1) begin
            mxs = 0; mys = (mys == SV_A + SV_F + SV_P + SV_B - 1) ? 0 : mys + 1;
          end else mxs++;
        end
        mt = 1 - mt;
      end
      @(negedge clk);
      check_all(rst_ni ? "run" : "R1 midreset");
      // directed colours and a reset mid-frame
      if (cyc % 97 == 0)       rgb_i = 3'b111;
      else if (cyc % 97 == 1)  rgb_i = 3'b001;
      else if (cyc % 97 == 2)  rgb_i = 3'b110;
      else                     rgb_i = 3'($urandom);
      if (cyc == 4100) rst_ni = 1'b0;
      if (cyc == 4103) rst_ni = 1'b1;
    end
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (NCYC * 2 + 1000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule